// File: doc/BRIEF.md
# Lossy Last-Value Fast Channel Bank

This block is a bank of message words that a sender may overwrite at any moment and a receiver may read at any moment. It acts like a small RAM. Every accepted write stores its data word and marks the target channel as having a fresh transfer. The receiver sees that mark as a level interrupt for the channel, and optionally as a level interrupt for each fixed group of channels. There is no back-pressure and no acknowledgement. A value the receiver never read is lost when the sender writes again. The sender has no way to learn whether, or when, a value was consumed.

The receiver selects a channel on its read port and gets the stored word in the same cycle. When it has handled a channel, it clears that channel's pending mark with a write-one clear strobe. The word width is 32 or 64 bits. The legal channel count depends on the width: up to 1024 channels at 32 bits and up to 512 at 64 bits. Both values are fixed parameters, and the block reports them on read-only configuration outputs.

Top module: `fch_bank`

## Requirements
- R1: A write with `wr_en` high replaces the word of channel `wr_idx` at the next clock edge. This holds even when that channel's pending bit is already set, and the bit then stays set.
- R2: `rd_data` returns the word last written to channel `rd_idx` combinationally. It shows a write from the cycle after the write's clock edge.
- R3: While `wr_en` is low, no stored word and no pending bit changes because of `wr_idx` or `wr_data`.
- R4: An accepted write sets the pending bit of its channel. `irq_ch[i]` equals that bit and is high from the cycle after the write edge.
- R5: `cfg_wide` is 1 exactly when the word width is 64. `cfg_count` equals the channel count. The channel count must lie in 1..1024 at 32 bits and in 1..512 at 64 bits.
- R6: `clr_en` clears the pending bit of channel `clr_idx` at the next edge and leaves the stored words unchanged. A clear of a bit that is already low has no effect.
- R7: With group interrupts enabled, `irq_grp[g]` is high exactly when some channel in g*GRP_SIZE .. g*GRP_SIZE+GRP_SIZE-1 is pending. With group interrupts disabled, `irq_grp` is all zero.
- R8: After reset every stored word reads zero and every pending bit is low.
- R9: When a write and a clear target the same channel in the same cycle, the pending bit ends set. When they target different channels, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Sender write strobe |
| wr_idx | input | IDX_W | Channel written |
| wr_data | input | WORD_W | Word written |
| rd_idx | input | IDX_W | Channel read by the receiver |
| rd_data | output | WORD_W | Last word stored in `rd_idx` |
| clr_en | input | 1 | Receiver write-one clear strobe |
| clr_idx | input | IDX_W | Channel whose pending bit is cleared |
| irq_ch | output | NUM_CH | Per-channel transfer interrupt levels |
| irq_grp | output | NUM_GRP | Per-group transfer interrupt levels |
| cfg_wide | output | 1 | 1 when the word width is 64 bits |
| cfg_count | output | 11 | Channel count |

## Verification
The bench drives the following stimulus patterns:
- Single writes to idle channels. These show that data and the interrupt arrive in the expected cycle.
- Repeated writes to a channel that is still pending. These separate the last-value overwrite from any buffering or from dropping the second write.
- A full sweep with a distinct word per channel, including the highest index. This exposes index aliasing in the store and in the group decode.
- Idle cycles with garbage on the write bus, clears of idle channels, and a write and clear that collide on one channel or on two different channels. These show that write enable, the clear, and the set-over-clear priority are each honoured on their own.

// File: rtl/fch_pkg.sv
package fch_pkg;

    localparam int unsigned FCH_LIMIT_W32 = 1024;
    localparam int unsigned FCH_LIMIT_W64 = 512;

    function automatic int unsigned fch_max_channels(input int unsigned word_w);
        return (word_w == 64) ? FCH_LIMIT_W64 : FCH_LIMIT_W32;
    endfunction

    function automatic int unsigned fch_ceil_div(input int unsigned a, input int unsigned b);
        return (a + b - 1) / b;
    endfunction

endpackage

// File: rtl/fch_store.sv
module fch_store #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [WORD_W-1:0] rd_data_o
);

    typedef struct packed {
        logic [NUM_CH-1:0][WORD_W-1:0] word;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i && (32'(wr_idx_i) < NUM_CH)) begin
            st_d.word[wr_idx_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (32'(rd_idx_i) < NUM_CH) begin
            rd_data_o = st_q.word[rd_idx_i];
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && (32'(wr_idx_i) < NUM_CH) |=> st_q.word[$past(wr_idx_i)] == $past(wr_data_i)) // R2
        else $error("stored word differs from last write");

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(st_q)) // R3
        else $error("store changed without write enable");

endmodule

// File: rtl/fch_pending.sv
module fch_pending #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic              clr_en_i,
    input  logic [IDX_W-1:0]  clr_idx_i,
    output logic [NUM_CH-1:0] pend_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] pend;
    } pend_t;

    pend_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clear first so that a colliding write wins
        if (clr_en_i && (32'(clr_idx_i) < NUM_CH)) begin
            st_d.pend[clr_idx_i] = 1'b0;
        end
        if (wr_en_i && (32'(wr_idx_i) < NUM_CH)) begin
            st_d.pend[wr_idx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

    AST_WRITE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && (32'(wr_idx_i) < NUM_CH) |=> pend_o[$past(wr_idx_i)]) // R4
        else $error("write did not mark channel pending");

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i && (32'(clr_idx_i) < NUM_CH) && !(wr_en_i && wr_idx_i == clr_idx_i)
        |=> !pend_o[$past(clr_idx_i)]) // R6
        else $error("clear did not drop pending bit");

    AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ($countones(pend_o) <= $countones($past(pend_o)))) // R3
        else $error("pending bit set without write");

endmodule

// File: rtl/fch_group.sv
module fch_group #(
    parameter int unsigned NUM_CH    = 8,
    parameter int unsigned GRP_SIZE  = 4,
    parameter int unsigned NUM_GRP   = 2,
    parameter bit          GROUP_IRQ = 1'b1
) (
    input  logic [NUM_CH-1:0]  pend_i,
    output logic [NUM_GRP-1:0] grp_o
);

    generate
        if (GROUP_IRQ) begin : g_on
            for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
                localparam int unsigned LO = g * GRP_SIZE;
                localparam int unsigned HI = ((LO + GRP_SIZE) > NUM_CH) ? NUM_CH - 1 : LO + GRP_SIZE - 1;
                assign grp_o[g] = |pend_i[HI:LO];
            end
        end else begin : g_off
            assign grp_o = '0;
        end
    endgenerate

endmodule

// File: rtl/fch_bank.sv
module fch_bank #(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned NUM_CH    = 8,
    parameter int unsigned GRP_SIZE  = 4,
    parameter bit          GROUP_IRQ = 1'b1,
    localparam int unsigned IDX_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned NUM_GRP  = fch_pkg::fch_ceil_div(NUM_CH, GRP_SIZE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [WORD_W-1:0]  rd_data,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [NUM_CH-1:0]  irq_ch,
    output logic [NUM_GRP-1:0] irq_grp,
    output logic               cfg_wide,
    output logic [10:0]        cfg_count
);

    localparam int unsigned MAX_CH = fch_pkg::fch_max_channels(WORD_W);

    initial begin
        AST_LEGAL_SHAPE: assert ((WORD_W == 32 || WORD_W == 64) && NUM_CH >= 1 && NUM_CH <= MAX_CH
                                 && GRP_SIZE >= 1) // R5
            else $error("illegal width or channel count");
    end

    logic [NUM_CH-1:0] pend;

    fch_store #(.WORD_W(WORD_W), .NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data)
    );

    fch_pending #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .clr_en_i  (clr_en),
        .clr_idx_i (clr_idx),
        .pend_o    (pend)
    );

    fch_group #(.NUM_CH(NUM_CH), .GRP_SIZE(GRP_SIZE), .NUM_GRP(NUM_GRP), .GROUP_IRQ(GROUP_IRQ)) u_grp (
        .pend_i (pend),
        .grp_o  (irq_grp)
    );

    assign irq_ch    = pend;
    assign cfg_wide  = (WORD_W == 64);
    assign cfg_count = 11'(NUM_CH);

    generate
        if (GROUP_IRQ) begin : g_grp_chk
            AST_GROUP_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
                (|irq_grp) == (|irq_ch)) // R7
                else $error("group interrupts disagree with channel interrupts");
        end
    endgenerate

endmodule

// File: tb/fch_bank_test.sv
module fch_bank_test;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned NUM_CH = 8;
    localparam int unsigned GRP    = 4;
    localparam int unsigned IDX_W  = 3;
    localparam int unsigned NGRP   = 2;

    typedef enum logic [1:0] {K_READ, K_CH, K_GRP} kind_t;
    typedef struct {
        kind_t       kind;
        logic [63:0] exp;
        string       req;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, clr_en = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0, rd_idx = '0, clr_idx = '0;
    logic [WORD_W-1:0] wr_data = '0;
    logic [WORD_W-1:0] rd_data;
    logic [NUM_CH-1:0] irq_ch;
    logic [NGRP-1:0] irq_grp;
    logic cfg_wide;
    logic [10:0] cfg_count;

    int checks = 0, errors = 0;
    item_t q[$];
    logic [WORD_W-1:0] m_word [NUM_CH];
    logic [NUM_CH-1:0] m_pend = '0;

    always #10 clk = ~clk;

    fch_bank #(.WORD_W(WORD_W), .NUM_CH(NUM_CH), .GRP_SIZE(GRP), .GROUP_IRQ(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .clr_en(clr_en), .clr_idx(clr_idx),
        .irq_ch(irq_ch), .irq_grp(irq_grp), .cfg_wide(cfg_wide), .cfg_count(cfg_count)
    );

    // monitor: compares every queued expectation at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [63:0] act;
            it = q.pop_front();
            case (it.kind)
                K_READ:  act = 64'(rd_data);
                K_CH:    act = 64'(irq_ch);
                default: act = 64'(irq_grp);
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
        end
    end

    function automatic logic [NGRP-1:0] m_grp();
        logic [NGRP-1:0] g = '0;
        for (int i = 0; i < NUM_CH; i++) if (m_pend[i]) g[i / GRP] = 1'b1;
        return g;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push(kind_t k, logic [63:0] e, string r);
        item_t it;
        it.kind = k; it.exp = e; it.req = r;
        q.push_back(it);
    endtask

    task automatic expect_irq(string r);
        push(K_CH, 64'(m_pend), r);
        push(K_GRP, 64'(m_grp()), r);
    endtask

    task automatic do_read(int idx, string r);
        rd_idx = IDX_W'(idx);
        push(K_READ, 64'(m_word[idx]), r);
        step();
    endtask

    task automatic do_op(bit w, int widx, logic [WORD_W-1:0] d, bit c, int cidx, string r);
        wr_en = w; wr_idx = IDX_W'(widx); wr_data = d;
        clr_en = c; clr_idx = IDX_W'(cidx);
        step();
        wr_en = 1'b0; clr_en = 1'b0;
        if (c) m_pend[cidx] = 1'b0;
        if (w) begin m_word[widx] = d; m_pend[widx] = 1'b1; end
        expect_irq(r);
        step();
    endtask

    initial begin : watchdog
        #(20 * 20000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NUM_CH; i++) m_word[i] = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R8 reset state
        expect_irq("R8");
        do_read(0, "R8");
        do_read(7, "R8");
        // R5 configuration outputs
        checks++;
        if (cfg_wide !== 1'b0 || cfg_count !== 11'd8) begin
            errors++;
            $display("FAIL R5 actual=%b/%0d expected=0/8", cfg_wide, cfg_count);
        end
        // R2 R4 single write
        do_op(1, 3, 32'hA5A5_0003, 0, 0, "R4");
        do_read(3, "R2");
        // R1 overwrite while pending
        do_op(1, 3, 32'h1234_5678, 0, 0, "R1");
        do_op(1, 3, 32'hDEAD_BEEF, 0, 0, "R1");
        do_read(3, "R1");
        // R7 second group
        do_op(1, 6, 32'h0000_0066, 0, 0, "R7");
        // R6 clear keeps data
        do_op(0, 0, '0, 1, 3, "R6");
        do_read(3, "R6");
        do_op(0, 0, '0, 1, 0, "R6");
        do_op(0, 0, '0, 1, 6, "R7");
        // R3 garbage on bus without enable
        wr_idx = 3'd5; wr_data = 32'hFFFF_FFFF;
        step();
        wr_idx = 3'd0; wr_data = '0;
        expect_irq("R3");
        step();
        do_read(5, "R3");
        // R9 collisions
        do_op(1, 2, 32'h0000_0222, 1, 2, "R9");
        do_op(1, 5, 32'h0000_0555, 1, 2, "R9");
        // R2 sweep all channels
        for (int i = 0; i < NUM_CH; i++) do_op(1, i, 32'hC0DE_0000 + 32'(i * 17), 0, 0, "R2");
        for (int i = 0; i < NUM_CH; i++) do_read(i, "R2");
        for (int i = 0; i < NUM_CH; i++) do_op(0, 0, '0, 1, i, "R6");
        step();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule